// File: doc/BRIEF.md
# Prescaled Match Timer with PWM Outputs

This block is a free-running up-counter. A prescaler divides the peripheral clock before it reaches the counter. Four comparison channels watch the count. A channel that sees its value can flag an interrupt, send the count back to zero, or halt the timer. The reaction is chosen per channel, and any combination is allowed.

Each channel drives one output pin. In plain mode the pin shows a software-visible external-match bit, which a 2-bit action code changes on every match. In pulse-width mode the pin is low at the start of each period and goes high once the count reaches the channel's value. The highest channel normally defines the period by restarting the count.

Software reaches every setting through a word-addressed register port. The write side is synchronous and the read side is combinational. Everything runs on one clock with a synchronous, active-high reset.

Top module: `pmt_timer`

## Requirements
- R1: Register word addresses: 0 control (bit 0 = run), 1 count, 2 prescale limit, 3 prescale counter (read-only), 4 match actions, 5 external match, 6 interrupt flags, 7 pulse-width select, 8+n match value of channel n. After reset every one of them reads zero, all pins are low and the interrupt is low.
- R2: While running, the prescale counter steps 0,1,...,limit and wraps. The count rises by one at each wrap, so it advances once per limit+1 clocks. While not running, both counters hold their values. Writing the count also zeroes the prescale counter.
- R3: When a channel's restart bit (bit 3n+1 of the action word) is set, the count stays at that channel's match value for a full prescale period. It returns to zero at the edge that ends that period.
- R4: A channel matches in the cycle where the count equals its match value and the prescale counter is zero. If its interrupt bit (bit 3n) is set, its flag (bit n of the flag word) reads 1 from the following cycle onward. The interrupt output is the OR of the flags whose interrupt bit is set. Channels without the interrupt bit never raise it.
- R5: When a channel's halt bit (bit 3n+2) is set, the run bit reads 0 from the cycle after the match. The count and the prescale counter keep the values they had in the match cycle.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a match sets a flag in the same cycle that software clears it, the flag stays set.
- R7: The external-match word holds the bits for channel n at bit n. The action code for channel n sits in bits NCH+2n+1:NCH+2n. On each match the code applies: 00 keep, 01 clear, 10 set, 11 invert.
- R8: With pulse-width select bit n at 0, pin n shows external-match bit n. With the select bit at 1, the external-match bit has no effect on the pin.
- R9: In pulse-width mode, pin n is low from the first cycle of each period. It becomes high in the cycle after channel n matches and stays high through the last cycle of the period. If the match value lies beyond the period, the pin stays low. Restarting the count takes priority over setting the pin.
- R10: The pulse-width select word keeps only bits NCH-1:0. The remaining bits ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | DATA_W | Register read data (combinational) |
| mat_out | output | NCH | Per-channel match / pulse-width pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The sharpest collision is between a match that sets a channel's flag and a software write of 1 that clears the same flag in the same clock. The bench issues the clearing write exactly in a match cycle, then in a quiet cycle. It judges the outcome by the interrupt pin and the flag word in the cycle after each write. A second collision comes from the pulse-width logic: with a prescale limit of zero and a match value equal to the period, the set and the restart of a pin land on the same edge. The sweep over prescale limits covers this case, and the arithmetic pin model predicts the pin stays low.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   localparam int ADDR_W  = 4;
   localparam int ACT_W   = 3;
   localparam int MAX_CH  = 8;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_COUNT = 4'd1;
   localparam logic [ADDR_W-1:0] A_PLIM  = 4'd2;
   localparam logic [ADDR_W-1:0] A_PCNT  = 4'd3;
   localparam logic [ADDR_W-1:0] A_ACT   = 4'd4;
   localparam logic [ADDR_W-1:0] A_EXT   = 4'd5;
   localparam logic [ADDR_W-1:0] A_FLAG  = 4'd6;
   localparam logic [ADDR_W-1:0] A_PWM   = 4'd7;
   localparam int                A_MR0   = 8;

   // bit positions inside one channel's action field
   localparam int ACT_IRQ  = 0;
   localparam int ACT_RST  = 1;
   localparam int ACT_STOP = 2;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'b00,
      EXT_CLR  = 2'b01,
      EXT_SET  = 2'b10,
      EXT_INV  = 2'b11
   } ext_act_e;

endpackage

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ctrl_we,
   input  logic             ctrl_run,
   input  logic             cnt_we,
   input  logic             plim_we,
   input  logic [CNT_W-1:0] wval,
   input  logic             stop_req,
   input  logic             wrap_req,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] pcnt,
   output logic [CNT_W-1:0] plim,
   output logic             pcnt_zero,
   output logic             wrap
);

   logic adv;
   logic tick;

   // a halt request freezes both counters on its own edge
   assign adv       = run & ~stop_req;
   assign tick      = adv & (pcnt >= plim);
   assign wrap      = tick & wrap_req;
   assign pcnt_zero = (pcnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         run  <= 1'b0;
         cnt  <= '0;
         pcnt <= '0;
         plim <= '0;
      end else begin
         if (plim_we) plim <= wval;

         if (stop_req)     run <= 1'b0;
         else if (ctrl_we) run <= ctrl_run;

         if (cnt_we) begin
            cnt  <= wval;
            pcnt <= '0;
         end else if (adv) begin
            if (pcnt >= plim) begin
               pcnt <= '0;
               cnt  <= wrap_req ? '0 : cnt + CNT_W'(1);
            end else begin
               pcnt <= pcnt + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/pmt_channel.sv
module pmt_channel
   import pmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt,
   input  logic             pcnt_zero,
   input  logic             run,
   input  logic             wrap,
   input  logic             cnt_load,
   input  logic             mr_we,
   input  logic [CNT_W-1:0] mr_wdata,
   input  logic             act_we,
   input  logic [ACT_W-1:0] act_wdata,
   input  logic             ext_we,
   input  logic             ext_wdata,
   input  logic [1:0]       emc_wdata,
   input  logic             flag_clr,
   input  logic             pwm_we,
   input  logic             pwm_wdata,
   output logic             hit,
   output logic             rst_req,
   output logic             stop_req,
   output logic             flag,
   output logic             irq_en,
   output logic             ext,
   output logic             pwm_en,
   output logic             pin,
   output logic [CNT_W-1:0] mr,
   output logic [ACT_W-1:0] act,
   output logic [1:0]       emc
);

   logic eq;
   logic ext_nx;

   assign eq       = (cnt == mr);
   assign hit      = run & pcnt_zero & eq;
   assign rst_req  = act[ACT_RST] & eq;
   assign stop_req = act[ACT_STOP] & hit;
   assign irq_en   = act[ACT_IRQ];

   always_ff @(posedge clk) begin
      if (rst) begin
         mr  <= '0;
         act <= '0;
         emc <= '0;
      end else begin
         if (mr_we)  mr  <= mr_wdata;
         if (act_we) act <= act_wdata;
         if (ext_we) emc <= emc_wdata;
      end
   end

   always_comb begin
      unique case (ext_act_e'(emc))
         EXT_KEEP: ext_nx = ext;
         EXT_CLR:  ext_nx = 1'b0;
         EXT_SET:  ext_nx = 1'b1;
         EXT_INV:  ext_nx = ~ext;
         default:  ext_nx = ext;
      endcase
   end

   // hardware update wins over a software write in the same cycle
   always_ff @(posedge clk) begin
      if (rst)         ext <= 1'b0;
      else if (hit)    ext <= ext_nx;
      else if (ext_we) ext <= ext_wdata;
   end

   // sticky flag: set beats clear
   always_ff @(posedge clk) begin
      if (rst)                  flag <= 1'b0;
      else if (hit && irq_en)   flag <= 1'b1;
      else if (flag_clr)        flag <= 1'b0;
   end

   generate
      if (HAS_PWM) begin : g_pwm
         logic sel_q;
         logic lvl_q;

         always_ff @(posedge clk) begin
            if (rst)         sel_q <= 1'b0;
            else if (pwm_we) sel_q <= pwm_wdata;
         end

         // restart of the period has priority over the rising edge
         always_ff @(posedge clk) begin
            if (rst)                  lvl_q <= 1'b0;
            else if (wrap || cnt_load) lvl_q <= 1'b0;
            else if (hit)             lvl_q <= 1'b1;
         end

         assign pwm_en = sel_q;
         assign pin    = sel_q ? lvl_q : ext;
      end else begin : g_nopwm
         assign pwm_en = 1'b0;
         assign pin    = ext;
      end
   endgenerate

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
   import pmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int NCH     = 4,
   parameter bit HAS_PWM = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [NCH-1:0]    mat_out,
   output logic              irq
);

   localparam int EXT_W = NCH * 3;
   localparam int ACT_TOT = NCH * ACT_W;

   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("pmt_timer: NCH must lie in 1..%0d", MAX_CH);
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("pmt_timer: CNT_W must lie in 2..DATA_W");
      end
      if (EXT_W > DATA_W || ACT_TOT > DATA_W) begin : g_bad_data
         $error("pmt_timer: DATA_W too narrow for channel fields");
      end
   endgenerate

   logic we_ctrl, we_cnt, we_plim, we_act, we_ext, we_flag, we_pwm;

   assign we_ctrl = wr_en && (wr_addr == A_CTRL);
   assign we_cnt  = wr_en && (wr_addr == A_COUNT);
   assign we_plim = wr_en && (wr_addr == A_PLIM);
   assign we_act  = wr_en && (wr_addr == A_ACT);
   assign we_ext  = wr_en && (wr_addr == A_EXT);
   assign we_flag = wr_en && (wr_addr == A_FLAG);
   assign we_pwm  = wr_en && (wr_addr == A_PWM);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q, pcnt_q, plim_q;
   logic             pcnt_zero, wrap;

   logic [NCH-1:0]             hit_v, rstq_v, stop_v, flag_v, irqen_v;
   logic [NCH-1:0]             ext_v, pwmen_v;
   logic [NCH-1:0][CNT_W-1:0]  mr_v;
   logic [NCH-1:0][ACT_W-1:0]  act_v;
   logic [NCH-1:0][1:0]        emc_v;

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .ctrl_we   (we_ctrl),
      .ctrl_run  (wr_data[0]),
      .cnt_we    (we_cnt),
      .plim_we   (we_plim),
      .wval      (wr_data[CNT_W-1:0]),
      .stop_req  (|stop_v),
      .wrap_req  (|rstq_v),
      .run       (run_q),
      .cnt       (cnt_q),
      .pcnt      (pcnt_q),
      .plim      (plim_q),
      .pcnt_zero (pcnt_zero),
      .wrap      (wrap)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         pmt_channel #(.CNT_W(CNT_W), .HAS_PWM(HAS_PWM)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cnt       (cnt_q),
            .pcnt_zero (pcnt_zero),
            .run       (run_q),
            .wrap      (wrap),
            .cnt_load  (we_cnt),
            .mr_we     (wr_en && (wr_addr == ADDR_W'(A_MR0 + c))),
            .mr_wdata  (wr_data[CNT_W-1:0]),
            .act_we    (we_act),
            .act_wdata (wr_data[ACT_W*c +: ACT_W]),
            .ext_we    (we_ext),
            .ext_wdata (wr_data[c]),
            .emc_wdata (wr_data[NCH + 2*c +: 2]),
            .flag_clr  (we_flag && wr_data[c]),
            .pwm_we    (we_pwm),
            .pwm_wdata (wr_data[c]),
            .hit       (hit_v[c]),
            .rst_req   (rstq_v[c]),
            .stop_req  (stop_v[c]),
            .flag      (flag_v[c]),
            .irq_en    (irqen_v[c]),
            .ext       (ext_v[c]),
            .pwm_en    (pwmen_v[c]),
            .pin       (mat_out[c]),
            .mr        (mr_v[c]),
            .act       (act_v[c]),
            .emc       (emc_v[c])
         );
      end
   endgenerate

   assign irq = |(flag_v & irqen_v);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL:  rd_data[0]         = run_q;
         A_COUNT: rd_data[CNT_W-1:0] = cnt_q;
         A_PLIM:  rd_data[CNT_W-1:0] = plim_q;
         A_PCNT:  rd_data[CNT_W-1:0] = pcnt_q;
         A_ACT: begin
            for (int c = 0; c < NCH; c++) rd_data[ACT_W*c +: ACT_W] = act_v[c];
         end
         A_EXT: begin
            rd_data[NCH-1:0] = ext_v;
            for (int c = 0; c < NCH; c++) rd_data[NCH + 2*c +: 2] = emc_v[c];
         end
         A_FLAG:  rd_data[NCH-1:0] = flag_v;
         A_PWM:   rd_data[NCH-1:0] = pwmen_v;
         default: begin
            for (int c = 0; c < NCH; c++) begin
               if (rd_addr == ADDR_W'(A_MR0 + c)) rd_data[CNT_W-1:0] = mr_v[c];
            end
         end
      endcase
   end

endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk
   import pmt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int NCH    = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  pcnt,
   input logic [CNT_W-1:0]  plim,
   input logic [NCH-1:0]    hit_v,
   input logic [NCH-1:0]    irqen_v,
   input logic [NCH-1:0]    flag_v,
   input logic [NCH-1:0]    stop_v,
   input logic [NCH-1:0]    rstq_v,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);

   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (run && !(|stop_v) && pcnt >= plim && !(|rstq_v) && !wr_en)
      |=> (cnt == $past(cnt) + CNT_W'(1)));

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
      (!run && !wr_en) |=> ($stable(cnt) && $stable(pcnt)));

   p_restart_r3: assert property (@(posedge clk) disable iff (rst)
      (run && !(|stop_v) && pcnt >= plim && (|rstq_v) && !wr_en)
      |=> (cnt == '0));

   p_halt_r5: assert property (@(posedge clk) disable iff (rst)
      (|stop_v) |=> !run);

   p_halt_freeze_r5: assert property (@(posedge clk) disable iff (rst)
      ((|stop_v) && !wr_en) |=> ($stable(cnt) && $stable(pcnt)));

   p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
      (|(hit_v & irqen_v))
      |=> ((flag_v & $past(hit_v & irqen_v)) == $past(hit_v & irqen_v)));

   p_pwm_rsvd_r10: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == A_PWM) |-> (rd_data[DATA_W-1:NCH] == '0));

endmodule

bind pmt_timer pmt_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NCH(NCH)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .run     (run_q),
   .cnt     (cnt_q),
   .pcnt    (pcnt_q),
   .plim    (plim_q),
   .hit_v   (hit_v),
   .irqen_v (irqen_v),
   .flag_v  (flag_v),
   .stop_v  (stop_v),
   .rstq_v  (rstq_v),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/pmt_timer_bench.sv
module pmt_timer_bench;
   import pmt_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [3:0]  mat_out;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] v;

   always #5 clk = ~clk;

   pmt_timer u_pmt_timer (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .mat_out (mat_out),
      .irq     (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic clean();
      wr(A_CTRL, 0);
      wr(A_ACT, 0);
      wr(A_EXT, 0);
      wr(A_PWM, 0);
      wr(A_FLAG, 32'hFFFF_FFFF);
      wr(A_COUNT, 0);
      wr(A_PLIM, 0);
   endtask

   initial begin
      #(10 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state of every register and output
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk("R1 reset register", v, 0);
      end
      chk("R1 reset pins", 32'(mat_out), 0);
      chk("R1 reset irq", 32'(irq), 0);
      @(negedge clk);

      // R2 R3 R4: restart on match, sweep of prescale limit and match value
      for (int p = 0; p < 4; p++) begin
         for (int m = 0; m < 5; m++) begin
            int len;
            clean();
            wr(A_PLIM, 32'(p));
            wr(4'd8, 32'(m));
            wr(A_ACT, 32'h3);
            wr(A_CTRL, 1);
            len = (m + 1) * (p + 1);
            for (int k = 0; k < 2 * len + 3; k++) begin
               rd(A_COUNT, v);
               chk("R3 count with restart", v, 32'((k / (p + 1)) % (m + 1)));
               rd(A_PCNT, v);
               chk("R2 prescale counter", v, 32'(k % (p + 1)));
               chk("R4 irq after first match", 32'(irq), 32'(k > m * (p + 1)));
               @(negedge clk);
            end
            wr(A_CTRL, 0);
            begin
               logic [31:0] held;
               rd(A_COUNT, held);
               repeat (5) @(negedge clk);
               rd(A_COUNT, v);
               chk("R2 count holds while stopped", v, held);
            end
         end
      end

      // R5: halt on match, channel 1
      for (int p = 0; p < 3; p += 2) begin
         for (int m = 1; m < 4; m += 2) begin
            int j;
            clean();
            wr(A_PLIM, 32'(p));
            wr(4'd9, 32'(m));
            wr(A_ACT, 32'h5 << 3);
            wr(A_CTRL, 1);
            j = m * (p + 1);
            for (int k = 0; k < j + 6; k++) begin
               rd(A_CTRL, v);
               chk("R5 run bit", v, 32'(k <= j));
               rd(A_COUNT, v);
               chk("R5 count frozen", v, (k <= j) ? 32'(k / (p + 1)) : 32'(m));
               rd(A_PCNT, v);
               chk("R5 prescaler frozen", v, (k <= j) ? 32'(k % (p + 1)) : 32'(0));
               chk("R5 irq with halt", 32'(irq), 32'(k > j));
               @(negedge clk);
            end
         end
      end

      // R7: external match actions, all channels matching together
      begin
         int len, j, n;
         logic [3:0] e;
         clean();
         wr(A_PLIM, 1);
         for (int c = 0; c < 4; c++) wr(4'(8 + c), 2);
         wr(A_ACT, 32'h2);
         wr(A_EXT, 32'h1BC);
         wr(A_CTRL, 1);
         len = 6; j = 4;
         for (int k = 0; k < 3 * len + 2; k++) begin
            n = (k > j) ? ((k - j - 1) / len) + 1 : 0;
            e = {1'b1, (n > 0) ? 1'b0 : 1'b1, (n > 0) ? 1'b1 : 1'b0, 1'(n % 2)};
            chk("R7 external match pins", 32'(mat_out), 32'(e));
            chk("R4 masked channels keep irq low", 32'(irq), 0);
            @(negedge clk);
         end
      end

      // R8 R9 R10: pulse-width mode, channel 3 sets the period
      for (int p = 0; p < 2; p++) begin
         int len, r;
         int mr [4];
         logic [3:0] e;
         mr[0] = 0; mr[1] = 3; mr[2] = 9; mr[3] = 7;
         clean();
         wr(A_PLIM, 32'(p));
         for (int c = 0; c < 4; c++) wr(4'(8 + c), 32'(mr[c]));
         wr(A_ACT, 32'h2 << 9);
         wr(A_EXT, 32'hF);
         wr(A_PWM, 32'hFFFF_FFFF);
         rd(A_PWM, v);
         chk("R10 select word reserved bits", v, 32'hF);
         wr(A_CTRL, 1);
         len = 8 * (p + 1);
         for (int k = 0; k < 2 * len + 3; k++) begin
            r = k % len;
            for (int c = 0; c < 4; c++) e[c] = (r > mr[c] * (p + 1));
            chk("R9 pulse-width pins", 32'(mat_out), 32'(e));
            @(negedge clk);
         end
         wr(A_PWM, 0);
         chk("R8 pins back to external bits", 32'(mat_out), 32'hF);
      end

      // R6: clear colliding with a set, then a clean clear
      clean();
      wr(4'd8, 2);
      wr(A_ACT, 32'h3);
      wr(A_CTRL, 1);
      repeat (5) @(negedge clk);
      chk("R6 flag before clear", 32'(irq), 1);
      wr(A_FLAG, 32'h1);
      rd(A_FLAG, v);
      chk("R6 set wins over clear", v, 32'h1);
      chk("R6 irq after colliding clear", 32'(irq), 1);
      wr(A_FLAG, 32'h1);
      rd(A_FLAG, v);
      chk("R6 clear in quiet cycle", v, 0);
      chk("R6 irq after clear", 32'(irq), 0);
      repeat (2) @(negedge clk);
      chk("R6 flag set again", 32'(irq), 1);
      wr(A_FLAG, 32'hE);
      chk("R6 writing zero keeps flag", 32'(irq), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule